// File: doc/BRIEF.md
# Multi-Context Platform Interrupt Controller

This block gathers a set of external interrupt sources and presents them to several target contexts, for example one per hart and privilege level. Each source has a gateway that turns its input into a pending bit. The gateway treats the input as a level or as a rising edge, depending on a per-source trigger-type bit. A context's request output rises when one of its enabled, pending sources has a priority above that context's threshold.

Software talks to the block over a simple 32-bit register bus that has a one-cycle registered read. A context reads its claim register to take the best eligible source. That read clears the source's pending bit, and its gateway then holds off until software writes the same ID back to signal completion. A pending source wakes every context that has it enabled, but only the first context to claim it gets its ID. Software can also inject interrupts by setting pending bits directly.

Top module: `intc_top`

## Requirements
- R1: After reset, every priority, enable bit, threshold, trigger-type bit and pending bit is 0. Every request output is low, and a claim read returns 0.
- R2: Source n's priority lives at byte address 4*n. A write above MAX_PRIO stores MAX_PRIO. ID 0 always reads 0 and ignores writes.
- R3: A read request, meaning bus_valid high and bus_write low, returns its data on bus_rdata with bus_rvalid high exactly one cycle later. bus_rvalid is low after any other cycle.
- R4: irq_o[c] is high one cycle after the state satisfies this condition: some source that is pending, enabled for context c and has priority 1 or more has a priority strictly greater than context c's threshold. A source with priority 0 never raises a request. Context c's threshold is at 0x200000 + 0x1000*c.
- R5: A read of context c's claim register (threshold address + 4) returns the ID of the pending source, enabled for c, with the highest nonzero priority. The threshold is not applied. Ties go to the lowest ID. The read clears that source's pending bit, and it returns 0 when no source qualifies.
- R6: Once one context has claimed a source, a claim by another context that has it enabled returns 0 if nothing else qualifies.
- R7: A level-mode source whose input stays high is not pending again between its claim and its completion. After completion it becomes pending again if the input is still high.
- R8: An edge-mode source is set pending by a rising input. While the source is claimed, at most one further rising edge is remembered, and it becomes pending after completion.
- R9: A completion write of a source ID to a context's claim register is ignored if that ID is not enabled for that context.
- R10: The pending word at 0x1000 shows source n at bit n. Writing it sets the sources whose bits are 1, leaves the others unchanged, and ignores bit 0.
- R11: The trigger-type word at 0x1080 holds source n at bit n, with 0 for level and 1 for edge. Context c's enable word is at 0x2000 + 0x80*c, with source n at bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC-1 | Interrupt inputs, bit n is source ID n (1..NUM_SRC-1) |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | bus_rdata holds the result of the previous cycle's read |
| irq_o | output | NUM_CTX | Interrupt request per context, registered |

## Verification
The assertions assume that source inputs are synchronous to clk and that the bus carries at most one access per cycle. They also assume that NUM_SRC is a multiple of 32. The rule that a source cannot be claimed twice is checked only on back-to-back claim reads: no completion or pending write can fall between them, so the second read must never return the ID the first one took. The bench keeps within these assumptions. It drives inputs and bus fields at the falling edge, runs one access per task, and completes every claimed source before moving to the next scenario.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Address map (byte offsets); software decodes these, so they are fixed.
  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] TRIG_BASE  = 32'h0000_1080;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam int          EN_SHIFT   = 7;   // 0x80 bytes per context
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam int          CTX_SHIFT  = 12;  // 0x1000 bytes per context
  localparam logic [31:0] CTX_OFF_THR   = 32'h0;
  localparam logic [31:0] CTX_OFF_CLAIM = 32'h4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_TRIG,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;
endpackage

// File: rtl/intc_gateway.sv
module intc_gateway (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic sw_set_i,
  input  logic take_i,
  input  logic done_i,
  output logic pend_o
);
  logic busy_q;
  logic held_q;
  logic prev_q;
  logic rise;

  assign rise = src_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      busy_q <= 1'b0;
      held_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (take_i) begin
        pend_o <= 1'b0;
        busy_q <= 1'b1;
        if (edge_mode_i && rise) held_q <= 1'b1;
      end else begin
        if (sw_set_i) pend_o <= 1'b1;
        if (!busy_q) begin
          if (edge_mode_i ? rise : src_i) pend_o <= 1'b1;
          if (held_q) begin
            pend_o <= 1'b1;
            held_q <= 1'b0;
          end
        end else if (edge_mode_i && rise) begin
          held_q <= 1'b1;
        end
        if (done_i) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDW    = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [NUM_SRC-1:0]              en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]               thr_i,
  output logic [IDW-1:0]                  best_id_o,
  output logic                            irq_o
);
  logic [PRIO_W-1:0] best_prio;

  // Strict comparison keeps the lowest ID on a priority tie.
  always_comb begin
    best_id_o = '0;
    best_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_prio)) begin
        best_id_o = IDW'(i);
        best_prio = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (best_prio > thr_i);
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CTX  = 2,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 5,
  parameter int ADDR_W   = 22,
  localparam int IDW       = $clog2(NUM_SRC),
  localparam int NUM_WORDS = NUM_SRC / 32,
  localparam int WIW       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int CIW       = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bus_valid,
  input  logic                               bus_write,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  output logic                               bus_rvalid,
  input  logic [NUM_SRC-1:0]                 pend_i,
  input  logic [NUM_CTX-1:0][IDW-1:0]        best_id_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]     prio_o,
  output logic [NUM_CTX-1:0][NUM_SRC-1:0]    en_o,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]     thr_o,
  output logic [NUM_SRC-1:1]                 trig_o,
  output logic [NUM_SRC-1:1]                 sw_set_o,
  output logic [NUM_SRC-1:1]                 take_o,
  output logic [NUM_SRC-1:1]                 done_o
);
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
  logic [NUM_SRC-1:0]              trig_q;

  logic [31:0]    a32;
  logic [31:0]    off;
  reg_sel_e       sel;
  logic [IDW-1:0] d_src;
  logic [WIW-1:0] d_word;
  logic [CIW-1:0] d_ctx;
  logic           wr, rd;
  logic [31:0]    rd_val;
  logic [PRIO_W-1:0] wclamp;

  assign a32 = {{(32-ADDR_W){1'b0}}, bus_addr};
  assign wr  = bus_valid &  bus_write;
  assign rd  = bus_valid & ~bus_write;
  assign wclamp = (bus_wdata > 32'(MAX_PRIO)) ? PRIO_W'(MAX_PRIO) : bus_wdata[PRIO_W-1:0];

  // Address decode
  always_comb begin
    sel    = SEL_NONE;
    d_src  = '0;
    d_word = '0;
    d_ctx  = '0;
    off    = '0;
    if (a32[1:0] == 2'b00) begin
      if (a32 < PEND_BASE) begin
        if ((a32 >> 2) < 32'(NUM_SRC)) begin
          sel   = SEL_PRIO;
          d_src = IDW'(a32 >> 2);
        end
      end else if (a32 < PEND_BASE + 32'(4 * NUM_WORDS)) begin
        sel    = SEL_PEND;
        d_word = WIW'((a32 - PEND_BASE) >> 2);
      end else if (a32 >= TRIG_BASE && a32 < TRIG_BASE + 32'(4 * NUM_WORDS)) begin
        sel    = SEL_TRIG;
        d_word = WIW'((a32 - TRIG_BASE) >> 2);
      end else if (a32 >= EN_BASE && a32 < EN_BASE + (32'(NUM_CTX) << EN_SHIFT)) begin
        off    = a32 - EN_BASE;
        d_ctx  = CIW'(off >> EN_SHIFT);
        d_word = WIW'((off & ((32'd1 << EN_SHIFT) - 32'd1)) >> 2);
        if (((off & ((32'd1 << EN_SHIFT) - 32'd1)) >> 2) < 32'(NUM_WORDS)) sel = SEL_EN;
      end else if (a32 >= CTX_BASE && a32 < CTX_BASE + (32'(NUM_CTX) << CTX_SHIFT)) begin
        off   = a32 - CTX_BASE;
        d_ctx = CIW'(off >> CTX_SHIFT);
        if ((off & ((32'd1 << CTX_SHIFT) - 32'd1)) == CTX_OFF_THR)   sel = SEL_THR;
        if ((off & ((32'd1 << CTX_SHIFT) - 32'd1)) == CTX_OFF_CLAIM) sel = SEL_CLAIM;
      end
    end
  end

  // Per-source strobes to the gateways
  always_comb begin
    for (int i = 1; i < NUM_SRC; i++) begin
      sw_set_o[i] = wr && (sel == SEL_PEND) && (d_word == WIW'(i / 32)) && bus_wdata[i % 32];
      take_o[i]   = rd && (sel == SEL_CLAIM) && (best_id_i[d_ctx] == IDW'(i));
      done_o[i]   = wr && (sel == SEL_CLAIM) && (bus_wdata == 32'(i)) && en_q[d_ctx][i];
    end
  end

  // Configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
      trig_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_PRIO: if (d_src != '0) prio_q[d_src] <= wclamp;
        SEL_TRIG: begin
          trig_q[d_word*32 +: 32] <= bus_wdata;
          trig_q[0] <= 1'b0;
        end
        SEL_EN: begin
          en_q[d_ctx][d_word*32 +: 32] <= bus_wdata;
          en_q[d_ctx][0] <= 1'b0;
        end
        SEL_THR: thr_q[d_ctx] <= wclamp;
        default: ;
      endcase
    end
  end

  // Read mux and registered read port
  always_comb begin
    case (sel)
      SEL_PRIO:  rd_val = 32'(prio_q[d_src]);
      SEL_PEND:  rd_val = pend_i[d_word*32 +: 32];
      SEL_TRIG:  rd_val = trig_q[d_word*32 +: 32];
      SEL_EN:    rd_val = en_q[d_ctx][d_word*32 +: 32];
      SEL_THR:   rd_val = 32'(thr_q[d_ctx]);
      SEL_CLAIM: rd_val = 32'(best_id_i[d_ctx]);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_val;
    end
  end

  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign thr_o  = thr_q;
  assign trig_o = trig_q[NUM_SRC-1:1];
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CTX  = 2,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 5,
  parameter int ADDR_W   = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:1]   src_irq,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CTX-1:0]   irq_o
);
  localparam int IDW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:1]                gw_pend;
  logic [NUM_SRC-1:0]                pend_vec;
  logic [NUM_SRC-1:1]                trig, sw_set, take, done;
  logic [NUM_SRC-1:0][PRIO_W-1:0]    prio;
  logic [NUM_CTX-1:0][NUM_SRC-1:0]   en;
  logic [NUM_CTX-1:0][PRIO_W-1:0]    thr;
  logic [NUM_CTX-1:0][IDW-1:0]       best_id;

  assign pend_vec = {gw_pend, 1'b0};

  intc_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W),
    .MAX_PRIO(MAX_PRIO), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pend_i(pend_vec), .best_id_i(best_id),
    .prio_o(prio), .en_o(en), .thr_o(thr), .trig_o(trig),
    .sw_set_o(sw_set), .take_o(take), .done_o(done)
  );

  for (genvar g = 1; g < NUM_SRC; g++) begin : g_gw
    intc_gateway u_gw (
      .clk(clk), .rst(rst),
      .src_i(src_irq[g]), .edge_mode_i(trig[g]),
      .sw_set_i(sw_set[g]), .take_i(take[g]), .done_i(done[g]),
      .pend_o(gw_pend[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .clk(clk), .rst(rst),
      .pend_i(pend_vec), .en_i(en[c]), .prio_i(prio), .thr_i(thr[c]),
      .best_id_o(best_id[c]), .irq_o(irq_o[c])
    );
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CTX  = 2,
  parameter int MAX_PRIO = 5,
  parameter int ADDR_W   = 22
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CTX-1:0] irq_o,
  input logic [NUM_SRC-1:0] pend
);
  logic [31:0] a32;
  logic is_claim, is_prio, prev_claim, prev_prio;

  assign a32 = {{(32-ADDR_W){1'b0}}, bus_addr};
  assign is_claim = (a32 >= CTX_BASE) && (a32 < CTX_BASE + (32'(NUM_CTX) << CTX_SHIFT))
                    && ((a32 & 32'hfff) == CTX_OFF_CLAIM);
  assign is_prio  = (a32 < 32'(4 * NUM_SRC)) && (a32[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_claim <= 1'b0;
      prev_prio  <= 1'b0;
    end else begin
      prev_claim <= bus_valid && !bus_write && is_claim;
      prev_prio  <= bus_valid && !bus_write && is_prio;
    end
  end

  assert_read_returns_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);
  assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
  assert_prio_clamped_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_prio) |-> (bus_rdata <= 32'(MAX_PRIO)));
  assert_claim_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_claim) |-> (bus_rdata < 32'(NUM_SRC)));
  assert_irq_needs_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |-> $past(|pend));
  assert_single_claim_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && prev_claim && bus_rdata != 32'd0 && bus_valid && !bus_write && is_claim)
      |=> (bus_rdata != $past(bus_rdata)));
endmodule

bind intc_top intc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .MAX_PRIO(MAX_PRIO), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .irq_o(irq_o), .pend(pend_vec)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:1] src_irq = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  irq_o;

  int total = 0, bad = 0;
  logic [31:0] rv, rv2;

  intc_top u0 (
    .clk(clk), .rst(rst), .src_irq(src_irq), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [21:0] a_prio(int n); return 22'(4 * n); endfunction
  function automatic logic [21:0] a_en(int c); return 22'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [21:0] a_thr(int c); return 22'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [21:0] a_clm(int c); return 22'(32'h200004 + 32'h1000 * c); endfunction
  localparam logic [21:0] A_PEND = 22'h1000;
  localparam logic [21:0] A_TRIG = 22'h1080;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R3 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse(int n);
    @(negedge clk); src_irq[n] = 1'b1;
    @(negedge clk); src_irq[n] = 1'b0;
  endtask

  // Bench model for the random phase
  int prio_m [32];
  logic [31:0] en_m, pend_m;
  int thr_m;

  function automatic int model_best(output int bp);
    int b = 0;
    bp = 0;
    for (int i = 1; i < 32; i++)
      if (pend_m[i] && en_m[i] && prio_m[i] > bp) begin b = i; bp = prio_m[i]; end
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'd0);
    rd(a_prio(1), rv); check("R1 prio", rv, 0);
    rd(a_en(0), rv);   check("R1 enable", rv, 0);
    rd(a_thr(1), rv);  check("R1 threshold", rv, 0);
    rd(A_PEND, rv);    check("R1 pending", rv, 0);
    rd(A_TRIG, rv);    check("R1 trigger", rv, 0);
    rd(a_clm(0), rv);  check("R1 claim", rv, 0);

    // R2 priority clamp and ID 0
    wr(a_prio(2), 7); rd(a_prio(2), rv); check("R2 clamp", rv, MAXP);
    wr(a_prio(2), 3); rd(a_prio(2), rv); check("R2 store", rv, 3);
    wr(a_prio(0), 4); rd(a_prio(0), rv); check("R2 id0", rv, 0);
    wr(a_prio(2), 0);

    // R10 software pending, R4 priority 0 never interrupts
    wr(A_PEND, 32'h0000_0041); rd(A_PEND, rv); check("R10 set", rv, 32'h40);
    wr(A_PEND, 32'h0); rd(A_PEND, rv); check("R10 zero no effect", rv, 32'h40);
    wr(a_en(0), 32'h40); settle();
    check("R4 prio0 no irq", 32'(irq_o[0]), 0);
    rd(a_clm(0), rv); check("R5 prio0 claim", rv, 0);
    wr(a_prio(6), 1); settle();
    check("R4 irq on", 32'(irq_o[0]), 1);
    rd(a_clm(0), rv); check("R5 claim", rv, 6);
    wr(a_clm(0), 6);
    rd(A_PEND, rv); check("R5 cleared", rv, 0);

    // R4 threshold, R5 claim ignores threshold
    wr(a_prio(4), 2); wr(a_en(0), 32'h10); wr(A_PEND, 32'h10);
    wr(a_thr(0), 2); settle();
    check("R4 at threshold", 32'(irq_o[0]), 0);
    wr(a_thr(0), 1); settle();
    check("R4 above threshold", 32'(irq_o[0]), 1);
    wr(a_thr(0), 2);
    rd(a_clm(0), rv); check("R5 threshold not applied", rv, 4);
    wr(a_clm(0), 4); wr(a_thr(0), 0);

    // R5 ordering and ties
    wr(a_prio(10), 5); wr(a_prio(11), 3); wr(a_prio(12), 5);
    wr(a_en(0), 32'h1c00); wr(A_PEND, 32'h1c00);
    rd(a_clm(0), rv); check("R5 tie low id", rv, 10); wr(a_clm(0), 10);
    rd(a_clm(0), rv); check("R5 tie next", rv, 12); wr(a_clm(0), 12);
    rd(a_clm(0), rv); check("R5 lower prio", rv, 11); wr(a_clm(0), 11);
    rd(a_clm(0), rv); check("R5 empty", rv, 0);

    // R6 multicast claim, back-to-back from two contexts
    wr(a_prio(3), 4); wr(a_en(0), 32'h8); wr(a_en(1), 32'h8); wr(A_PEND, 32'h8);
    settle();
    check("R6 irq ctx0", 32'(irq_o[0]), 1);
    check("R6 irq ctx1", 32'(irq_o[1]), 1);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a_clm(0);
    @(negedge clk); rv = bus_rdata; bus_addr = a_clm(1);
    @(negedge clk); rv2 = bus_rdata; bus_valid = 1'b0;
    check("R6 first claimer", rv, 3);
    check("R6 second gets zero", rv2, 0);
    wr(a_clm(0), 3); settle();
    check("R6 irq drops", 32'(irq_o), 0);
    wr(a_en(1), 0);

    // R7 level gateway
    wr(a_prio(5), 3); wr(a_en(0), 32'h20);
    @(negedge clk); src_irq[5] = 1'b1;
    rd(A_PEND, rv); check("R7 level pend", rv, 32'h20);
    rd(a_clm(0), rv); check("R7 claim", rv, 5);
    rd(a_clm(0), rv); check("R7 no repend while busy", rv, 0);
    rd(A_PEND, rv); check("R7 pend clear while busy", rv, 0);
    wr(a_clm(0), 5);
    rd(A_PEND, rv); check("R7 repend after complete", rv, 32'h20);
    src_irq[5] = 1'b0;
    rd(a_clm(0), rv); check("R7 reclaim", rv, 5); wr(a_clm(0), 5);

    // R9 completion from a context without the enable
    wr(a_prio(9), 2); wr(a_en(0), 32'h200);
    @(negedge clk); src_irq[9] = 1'b1;
    rd(a_clm(0), rv); check("R9 claim", rv, 9);
    wr(a_clm(1), 9);
    rd(A_PEND, rv); check("R9 foreign complete ignored", rv, 0);
    wr(a_clm(0), 9);
    rd(A_PEND, rv); check("R9 own complete", rv, 32'h200);
    src_irq[9] = 1'b0;
    rd(a_clm(0), rv); check("R9 reclaim", rv, 9); wr(a_clm(0), 9);

    // R8 edge gateway, R11 trigger word
    wr(A_TRIG, 32'h81); rd(A_TRIG, rv); check("R11 trigger bits", rv, 32'h80);
    wr(a_prio(7), 2); wr(a_en(1), 32'h80); wr(a_en(0), 0);
    pulse(7);
    rd(A_PEND, rv); check("R8 edge pend", rv, 32'h80);
    rd(a_clm(1), rv); check("R8 claim", rv, 7);
    pulse(7); pulse(7);
    rd(a_clm(1), rv); check("R8 no pend while busy", rv, 0);
    wr(a_clm(1), 7);
    rd(A_PEND, rv); check("R8 held edge forwarded", rv, 32'h80);
    rd(a_clm(1), rv); check("R8 reclaim", rv, 7);
    wr(a_clm(1), 7);
    rd(a_clm(1), rv); check("R8 only one held", rv, 0);
    wr(A_TRIG, 0); wr(a_en(1), 0);

    // Random phase: R4 and R5 against the bench model
    for (int i = 0; i < 32; i++) prio_m[i] = 0;
    rd(A_PEND, rv); check("R5 clean before random", rv, 0);
    pend_m = '0;
    for (int it = 0; it < 40; it++) begin
      int bp, b, pv;
      logic [31:0] pm;
      for (int s = 1; s < 32; s++) begin
        pv = int'($urandom_range(0, 7));
        wr(a_prio(s), 32'(pv));
        prio_m[s] = (pv > MAXP) ? MAXP : pv;
      end
      en_m = $urandom() & 32'hffff_fffe;
      wr(a_en(0), en_m);
      thr_m = int'($urandom_range(0, MAXP));
      wr(a_thr(0), 32'(thr_m));
      pm = $urandom() & $urandom() & 32'hffff_fffe;
      wr(A_PEND, pm);
      pend_m = pend_m | pm;
      settle();
      b = model_best(bp);
      check("R4 random irq", 32'(irq_o[0]), 32'(bp > thr_m));
      rd(a_clm(0), rv);
      check("R5 random claim", rv, 32'(b));
      if (b != 0) begin
        pend_m[b] = 1'b0;
        wr(a_clm(0), 32'(b));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule